// File: doc/BRIEF.md
# Serial Clock-Calendar Register Port

This block is the slave side of the serial link of a real-time-clock device. The host selects it with an active-high select line. The host then shifts in a command byte and then one or more data bytes, most significant bit first. The block uses the command byte to pick a register and an access mode, and then reads or writes a file of sixteen 8-bit registers. These registers hold the time, calendar, alarm and control settings, but here they are plain storage: nothing counts, oscillates or matches alarms.

The serial clock idles low. The host changes its data bit on each rising serial-clock edge, and the slave samples it on the following falling edge. The slave likewise updates its data output after each rising edge, so the host can capture it on the falling edge. All serial inputs are oversampled by the block's own clock through a synchronizer. A parallel side port lets a local agent preload or inspect any register. Burst access lets a host move the whole seconds-to-year group within one select period, so the group it sees is coherent.

Top module: `rtc_spi_regif`

## Requirements
- R1: After reset every register reads 0x00 through the side port, except register 15, which reads 0x10 (oscillator-stopped flag), and `sdo` is 0.
- R2: The command byte carries the register address in bits 7:4. Bit 3 set selects single access and clear selects burst. Bit 2 set selects read and clear selects write. Bits 1:0 are ignored. All bytes travel MSB first.
- R3: A single write (low nibble 0x8) stores the first data byte at the addressed register. Any further bytes in the same select period change nothing.
- R4: In a single read (low nibble 0xC), the first data byte on `sdo` is the addressed register, MSB first, with each bit valid from shortly after a rising `sclk` edge through the next falling edge. Later bytes in the same select period read as 0x00.
- R5: A burst write (low nibble 0x0) stores successive data bytes at successive addresses, wrapping from 15 to 0.
- R6: A burst read (low nibble 0x4) returns successive registers starting at the addressed one, wrapping from 15 to 0. Seven bytes from address 0 return seconds through year in one select period.
- R7: Dropping `cs` before a byte's eighth bit discards that byte, leaves every register unchanged by it, and the next select period starts with a fresh command byte.
- R8: Register 13 always reads 0x00, and writes to it from either port are ignored.
- R9: While `cs` is low, `sdo` is 0 from no later than three clock cycles after `cs` falls.
- R10: A side-port write (`host_we` high) stores `host_wdata` at `host_addr` on the next clock edge. `host_rdata` always shows the register at `host_addr` with no clock delay. The stored value is visible to later serial reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, used to oversample the serial lines |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs | input | 1 | Serial select, active high |
| sclk | input | 1 | Serial clock, idles low |
| sdi | input | 1 | Serial data from host, sampled on falling sclk |
| sdo | output | 1 | Serial data to host, changes after rising sclk |
| host_we | input | 1 | Side-port write strobe |
| host_addr | input | 4 | Side-port register address |
| host_wdata | input | 8 | Side-port write data |
| host_rdata | output | 8 | Side-port read data (combinational) |

## Verification
The assertions assume that `cs`, `sclk` and `sdi` change slowly compared with `clk`, so that each serial edge shows up as exactly one synchronized pulse. They also assume that `sdi` is stable across a falling `sclk` edge. The stimulus holds every serial half period for six clock cycles and changes `sdi` only together with a rising `sclk`. It waits several cycles after raising `cs` before the first edge, and it never strobes the side port while a serial byte is being completed.

// File: rtl/rtc_spi_pkg.sv
package rtc_spi_pkg;
    localparam int ADDR_W   = 4;
    localparam int DATA_W   = 8;
    localparam int NUM_REGS = 1 << ADDR_W;
    localparam int BIT_CNT_W = $clog2(DATA_W);

    // command low nibble layout
    localparam int CMD_SINGLE_BIT = 3;
    localparam int CMD_READ_BIT   = 2;

    typedef enum logic [1:0] {
        PH_CMD  = 2'd0,
        PH_DATA = 2'd1,
        PH_DONE = 2'd2
    } phase_e;

    typedef struct packed {
        phase_e                 phase;
        logic [BIT_CNT_W-1:0]   bitcnt;
        logic [DATA_W-1:0]      rx;
        logic [DATA_W-1:0]      tx;
        logic [ADDR_W-1:0]      addr;
        logic                   single;
        logic                   rd;
        logic                   sdo;
    } eng_s;
endpackage

// File: rtl/rtc_spi_sync.sv
module rtc_spi_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] lvl,
    output logic [WIDTH-1:0] rise,
    output logic [WIDTH-1:0] fall
);
    localparam int DEPTH = STAGES + 1;

    logic [DEPTH-1:0][WIDTH-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d = {pipe_q[DEPTH-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign lvl  = pipe_q[STAGES-1];
    assign rise = pipe_q[STAGES-1] & ~pipe_q[STAGES];
    assign fall = ~pipe_q[STAGES-1] & pipe_q[STAGES];

    // an edge pulse never lasts two cycles
    a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (rise != '0) |=> ((rise & $past(rise)) == '0));
endmodule

// File: rtl/rtc_spi_engine.sv
module rtc_spi_engine
    import rtc_spi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_s,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic              sdi_s,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] rd_data,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              sdo
);
    localparam logic [BIT_CNT_W-1:0] LAST_BIT = BIT_CNT_W'(DATA_W - 1);

    eng_s q, d;
    logic [DATA_W-1:0] byte_in;
    logic              byte_done;

    always_comb begin
        d         = q;
        byte_in   = {q.rx[DATA_W-2:0], sdi_s};
        byte_done = sclk_fall && (q.bitcnt == LAST_BIT);
        wr_en     = 1'b0;
        wr_addr   = q.addr;
        wr_data   = byte_in;
        rd_addr   = (q.phase == PH_CMD) ? byte_in[DATA_W-1 -: ADDR_W] : q.addr + 1'b1;

        if (!cs_s) begin
            d.phase  = PH_CMD;
            d.bitcnt = '0;
            d.rx     = '0;
            d.tx     = '0;
            d.sdo    = 1'b0;
        end else begin
            if (sclk_rise) begin
                d.sdo = q.tx[DATA_W-1];
                d.tx  = {q.tx[DATA_W-2:0], 1'b0};
            end
            if (sclk_fall) begin
                d.rx     = byte_in;
                d.bitcnt = q.bitcnt + 1'b1;
                if (byte_done) begin
                    unique case (q.phase)
                        PH_CMD: begin
                            d.addr   = byte_in[DATA_W-1 -: ADDR_W];
                            d.single = byte_in[CMD_SINGLE_BIT];
                            d.rd     = byte_in[CMD_READ_BIT];
                            d.phase  = PH_DATA;
                            d.tx     = byte_in[CMD_READ_BIT] ? rd_data : '0;
                        end
                        PH_DATA: begin
                            wr_en = !q.rd;
                            if (q.single) begin
                                d.phase = PH_DONE;
                                d.tx    = '0;
                            end else begin
                                d.addr = q.addr + 1'b1;
                                d.tx   = q.rd ? rd_data : '0;
                            end
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sdo = q.sdo;

    a_r9_sdo_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_s |=> !sdo);
    a_r3_single_once: assert property (@(posedge clk) disable iff (!rst_n)
        (q.phase == PH_DONE) |-> !wr_en);
    a_r7_count_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_s && !sclk_fall) |=> $stable(q.bitcnt));
    a_r5_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_s && byte_done && q.phase == PH_DATA && !q.single)
        |=> (q.addr == $past(q.addr) + 1'b1));
endmodule

// File: rtl/rtc_regfile.sv
module rtc_regfile
    import rtc_spi_pkg::*;
#(
    parameter int                HOLE_ADDR = 13,
    parameter int                FLAG_ADDR = 15,
    parameter logic [DATA_W-1:0] FLAG_RST  = 8'h10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    input  logic              spi_we,
    input  logic [ADDR_W-1:0] spi_waddr,
    input  logic [DATA_W-1:0] spi_wdata,
    input  logic [ADDR_W-1:0] spi_raddr,
    output logic [DATA_W-1:0] spi_rdata
);
    logic [DATA_W-1:0] regs_d [NUM_REGS];
    logic [DATA_W-1:0] regs_q [NUM_REGS];

    always_comb begin
        for (int i = 0; i < NUM_REGS; i++) begin
            regs_d[i] = regs_q[i];
            if (i != HOLE_ADDR) begin
                if (host_we && host_addr == ADDR_W'(i))
                    regs_d[i] = host_wdata;
                else if (spi_we && spi_waddr == ADDR_W'(i))
                    regs_d[i] = spi_wdata;
            end
        end
    end

    generate
        for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
            localparam logic [DATA_W-1:0] RST_VAL = (g == FLAG_ADDR) ? FLAG_RST : '0;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) regs_q[g] <= RST_VAL;
                else        regs_q[g] <= regs_d[g];
            end
        end
    endgenerate

    assign host_rdata = regs_q[host_addr];
    assign spi_rdata  = regs_q[spi_raddr];

    a_r8_hole_empty: assert property (@(posedge clk) disable iff (!rst_n)
        regs_q[HOLE_ADDR] == '0);
    a_r3_spi_store: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_we && spi_waddr != ADDR_W'(HOLE_ADDR) && !(host_we && host_addr == spi_waddr))
        |=> (regs_q[$past(spi_waddr)] == $past(spi_wdata)));
    a_r10_host_store: assert property (@(posedge clk) disable iff (!rst_n)
        (host_we && host_addr != ADDR_W'(HOLE_ADDR))
        |=> (regs_q[$past(host_addr)] == $past(host_wdata)));
endmodule

// File: rtl/rtc_spi_regif.sv
module rtc_spi_regif
    import rtc_spi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs,
    input  logic              sclk,
    input  logic              sdi,
    output logic              sdo,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata
);
    localparam int SYNC_W = 3;

    logic [SYNC_W-1:0] lvl, rise, fall;
    logic [ADDR_W-1:0] rd_addr, wr_addr;
    logic [DATA_W-1:0] rd_data, wr_data;
    logic              wr_en;

    rtc_spi_sync #(.WIDTH(SYNC_W), .STAGES(2)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({cs, sclk, sdi}),
        .lvl   (lvl),
        .rise  (rise),
        .fall  (fall)
    );

    rtc_spi_engine i_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_s      (lvl[2]),
        .sclk_rise (rise[1]),
        .sclk_fall (fall[1]),
        .sdi_s     (lvl[0]),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .sdo       (sdo)
    );

    rtc_regfile i_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .spi_we     (wr_en),
        .spi_waddr  (wr_addr),
        .spi_wdata  (wr_data),
        .spi_raddr  (rd_addr),
        .spi_rdata  (rd_data)
    );
endmodule

// File: tb/test_rtc_spi_regif.sv
module test_rtc_spi_regif;
    localparam int HALF = 6;

    typedef struct {
        logic [7:0] val;
        string      req;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs = 1'b0, sclk = 1'b0, sdi = 1'b0;
    logic       sdo;
    logic       host_we = 1'b0;
    logic [3:0] host_addr = '0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;

    int checks = 0, errors = 0;
    logic [7:0] mdl [16];
    exp_t       exp_q [$];
    logic [7:0] got_q [$];
    logic [7:0] mon_got;
    exp_t       mon_exp;
    logic [7:0] junk;

    always #4 clk = ~clk;

    rtc_spi_regif i_rtc_spi_regif (
        .clk(clk), .rst_n(rst_n), .cs(cs), .sclk(sclk), .sdi(sdi), .sdo(sdo),
        .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata)
    );

    // monitor: compare each received serial byte with the next expected one
    always @(negedge clk) begin
        if (got_q.size() > 0) begin
            mon_got = got_q.pop_front();
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL unexpected byte: got %h exp none", mon_got);
            end else begin
                mon_exp = exp_q.pop_front();
                if (mon_got !== mon_exp.val) begin
                    errors++;
                    $display("FAIL %s serial read: got %h exp %h", mon_exp.req, mon_got, mon_exp.val);
                end
            end
        end
    end

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h exp %h", req, act, exp);
        end
    endtask

    task automatic spi_bits(input logic [7:0] mosi, input int nbits, output logic [7:0] miso);
        miso = '0;
        for (int i = 7; i >= 8 - nbits; i--) begin
            sclk = 1'b1;
            sdi  = mosi[i];
            wclk(HALF);
            miso[i] = sdo;
            sclk = 1'b0;
            wclk(HALF);
        end
    endtask

    task automatic sel();
        cs = 1'b1;
        wclk(6);
    endtask

    task automatic desel();
        wclk(4);
        cs = 1'b0;
        wclk(8);
    endtask

    function automatic logic [3:0] step(input logic [3:0] a, input int k);
        return 4'(a + k);
    endfunction

    task automatic mdl_write(input logic [3:0] a, input logic [7:0] v);
        if (a != 4'd13) mdl[a] = v;
    endtask

    task automatic burst_write(input logic [3:0] a, input int n, input logic [7:0] dat [8]);
        sel();
        spi_bits({a, 4'b0000}, 8, junk);
        for (int k = 0; k < n; k++) begin
            spi_bits(dat[k], 8, junk);
            mdl_write(step(a, k), dat[k]);
        end
        desel();
    endtask

    task automatic single_write(input logic [3:0] a, input logic [7:0] v);
        sel();
        spi_bits({a, 4'b1000}, 8, junk);
        spi_bits(v, 8, junk);
        spi_bits(8'hFF, 8, junk);   // extra byte must be ignored
        mdl_write(a, v);
        desel();
    endtask

    task automatic burst_read(input logic [3:0] a, input int n, input string req);
        logic [7:0] got;
        exp_t e;
        sel();
        spi_bits({a, 4'b0100}, 8, junk);
        for (int k = 0; k < n; k++) begin
            e.val = mdl[step(a, k)];
            e.req = req;
            exp_q.push_back(e);
            spi_bits(8'h00, 8, got);
            got_q.push_back(got);
        end
        desel();
    endtask

    task automatic single_read(input logic [3:0] a, input logic [3:0] lo, input int n, input string req);
        logic [7:0] got;
        exp_t e;
        sel();
        spi_bits({a, lo}, 8, junk);
        for (int k = 0; k < n; k++) begin
            e.val = (k == 0) ? mdl[a] : 8'h00;
            e.req = req;
            exp_q.push_back(e);
            spi_bits(8'h00, 8, got);
            got_q.push_back(got);
        end
        wclk(4);
        cs = 1'b0;
        wclk(3);
        check("R9 sdo low after deselect", {7'd0, sdo}, 8'h00);
        wclk(5);
    endtask

    task automatic host_wr(input logic [3:0] a, input logic [7:0] v);
        host_addr  = a;
        host_wdata = v;
        host_we    = 1'b1;
        wclk(1);
        host_we    = 1'b0;
        mdl_write(a, v);
    endtask

    task automatic host_chk(input string req, input logic [3:0] a);
        host_addr = a;
        wclk(1);
        check(req, host_rdata, mdl[a]);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout exp completion");
        finish_run();
    end

    initial begin
        logic [7:0] dat [8];
        for (int i = 0; i < 16; i++) mdl[i] = 8'h00;
        mdl[15] = 8'h10;
        wclk(5);
        rst_n = 1'b1;
        wclk(2);

        // R1: reset contents and idle output
        for (int i = 0; i < 16; i++) host_chk("R1 reset value", 4'(i));
        check("R1 sdo idle", {7'd0, sdo}, 8'h00);

        // R3: single write, trailing byte ignored
        single_write(4'd2, 8'h23);
        host_chk("R3 single write stored", 4'd2);
        host_chk("R3 trailing byte ignored", 4'd3);

        // R5: burst write of the time group
        dat = '{8'h45, 8'h59, 8'h23, 8'h06, 8'h31, 8'h12, 8'h99, 8'h00};
        burst_write(4'd0, 7, dat);
        for (int i = 0; i < 7; i++) host_chk("R5 burst write", 4'(i));

        // R5: burst write wrapping 14,15,0 (clears oscillator flag)
        dat = '{8'h20, 8'h00, 8'h11, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
        burst_write(4'd14, 3, dat);
        host_chk("R5 wrap reg14", 4'd14);
        host_chk("R5 wrap reg15", 4'd15);
        host_chk("R5 wrap reg0", 4'd0);

        // R6: coherent burst read of seconds..year, then wrap over hole
        burst_read(4'd0, 7, "R6 burst read");
        burst_read(4'd12, 5, "R6 R8 burst read wrap");

        // R4: single read, second byte zero; R2 with low bits set
        single_read(4'd5, 4'b1100, 2, "R4 single read");
        single_read(4'd6, 4'b1111, 1, "R2 low bits ignored");

        // R8: hole register ignores both ports
        single_write(4'd13, 8'hAA);
        host_wr(4'd13, 8'h55);
        host_chk("R8 hole reads zero", 4'd13);
        single_read(4'd13, 4'b1100, 1, "R8 hole serial read");

        // R10: side port write seen by serial read
        host_wr(4'd9, 8'h77);
        host_chk("R10 host write", 4'd9);
        single_read(4'd9, 4'b1100, 1, "R10 host value via serial");

        // R7: partial data byte discarded
        sel();
        spi_bits({4'd4, 4'b0000}, 8, junk);
        spi_bits(8'hA5, 8, junk);
        spi_bits(8'hFF, 3, junk);
        desel();
        mdl_write(4'd4, 8'hA5);
        host_chk("R7 full byte kept", 4'd4);
        host_chk("R7 partial byte discarded", 4'd5);

        // R7: partial command then a fresh transaction
        sel();
        spi_bits(8'hFF, 5, junk);
        desel();
        single_read(4'd1, 4'b1100, 1, "R7 fresh command after abort");

        wait (got_q.size() == 0);
        wclk(4);
        if (exp_q.size() != 0) begin
            checks++;
            errors++;
            $display("FAIL R6 missing bytes: got %0d exp 0", exp_q.size());
        end
        finish_run();
    end
endmodule